// File: doc/BRIEF.md
# Multi-Context Reconfigurable Array Cell

This block is a single compute cell meant to be tiled in a two-dimensional mesh of identical cells. Each cycle it takes two operands, runs one 16-bit arithmetic or logic operation on them, shifts the result right for fixed-point work, and registers it. The registered result goes to all four neighbours. It is also fed back into the cell as an operand and can be stored in a small local scratchpad.

Two operand selectors decide where each operand comes from. The choices are any of the four neighbour inputs, the scratchpad read data, a constant held in the configuration, the cell's own previous result, or zero. A bank of eight configuration words sets which operation runs and where its operands come from. A context counter steps through this bank. Every cell in the array sees the same run signal and the same last-context setting, so all cells walk their banks in lockstep. A cell can therefore run a different kernel in each context.

The configuration bank is filled through a load port while the array is halted.

Top module: `cgra_cell`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result` to 0 and sets `ctxIdx` to 0.
- R2: The configuration word is 35 bits. From MSB to LSB it holds: opcode [34:31], operand A select [30:28], operand B select [27:25], constant [24:9], shift amount [8:5], scratchpad write enable [4], scratchpad address [3:0]. The word on `cfgWord` is stored into context `cfgIdx` at a clock edge where `cfgWe` is high and `run` is low. A load attempted while `run` is high is ignored.
- R3: Operand select codes: 0 north, 1 south, 2 east, 3 west, 4 scratchpad read data, 5 configured constant, 6 own registered result, 7 zero.
- R4: Opcodes: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 low 16 bits of A×B, 6 pass A, 7 A shifted left by B[3:0]. Unused opcodes give 0. All arithmetic wraps modulo 2^16.
- R5: Before it is registered, the operation's output is shifted right logically by the configured shift amount.
- R6: While `run` is low, `result` and `ctxIdx` hold their values, whatever the inputs do.
- R7: Selecting the own result as an operand gives the value registered at the previous run cycle, so repeated additions accumulate.
- R8: The scratchpad has 16 words. Its read is combinational from the configured address. When the write enable bit is set, the value registered into `result` is also written at the configured address at that same run edge.
- R9: On each run cycle `ctxIdx` advances by one. If `ctxIdx` is greater than or equal to `lastCtx`, it goes to 0 instead. The configuration used in a cycle is the one at the current `ctxIdx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Shared enable; cell computes and steps context when high |
| cfgWe | input | 1 | Configuration load strobe |
| cfgIdx | input | 3 | Context slot to load |
| cfgWord | input | 35 | Configuration word to load |
| lastCtx | input | 3 | Highest context before wrapping to 0 |
| nIn | input | 16 | North neighbour result |
| sIn | input | 16 | South neighbour result |
| eIn | input | 16 | East neighbour result |
| wIn | input | 16 | West neighbour result |
| result | output | 16 | Registered cell result sent to neighbours |
| ctxIdx | output | 3 | Current context index |

## Verification
A wrong context counter shows on `ctxIdx` at the first run edge. It also shows in `result` one edge later, because the wrong configuration has been applied. A wrong scratchpad write stays hidden until a later context reads that address. The tests therefore pair a write context with a read context and change the neighbour inputs in between, so the value read back can only have come from the store. A wrong feedback path or a missing hold shows as accumulation sums drifting within two or three run cycles.

// File: rtl/cgra_cell_pkg.sv
package cgra_cell_pkg;
  localparam int DW    = 16;
  localparam int CTXN  = 8;
  localparam int CTXW  = $clog2(CTXN);
  localparam int MEMN  = 16;
  localparam int MEMAW = $clog2(MEMN);
  localparam int SHW   = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
    OP_XOR = 4'd4, OP_MUL = 4'd5, OP_PASS = 4'd6, OP_SHL = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    SRC_N = 3'd0, SRC_S = 3'd1, SRC_E = 3'd2, SRC_W = 3'd3,
    SRC_MEM = 3'd4, SRC_CONST = 3'd5, SRC_FB = 3'd6, SRC_ZERO = 3'd7
  } src_e;

  typedef struct packed {
    op_e              op;
    src_e             selA;
    src_e             selB;
    logic [DW-1:0]    konst;
    logic [SHW-1:0]   shamt;
    logic             memWe;
    logic [MEMAW-1:0] memAddr;
  } cfg_t;

  localparam int CFGW = $bits(cfg_t);

  typedef struct packed {
    logic step;
    cfg_t cfg;
  } ctl_t;
endpackage

// File: rtl/cgra_cell_ctrl.sv
module cgra_cell_ctrl
  import cgra_cell_pkg::*;
#(
  parameter int NCTX = CTXN,
  localparam int IW = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            cfgWe,
  input  logic [IW-1:0]   cfgIdx,
  input  logic [CFGW-1:0] cfgWord,
  input  logic [IW-1:0]   lastCtx,
  output ctl_t            ctl,
  output logic [IW-1:0]   ctxIdx
);
  cfg_t cfgMem [NCTX];
  logic [IW-1:0] ctxQ;

  // loads only accepted while halted so the active word never changes mid-run
  always_ff @(posedge clk) begin
    if (cfgWe && !run) cfgMem[cfgIdx] <= cfg_t'(cfgWord);
  end

  always_ff @(posedge clk) begin
    if (rst)                  ctxQ <= '0;
    else if (run) begin
      if (ctxQ >= lastCtx)    ctxQ <= '0;
      else                    ctxQ <= ctxQ + IW'(1);
    end
  end

  always_comb begin
    ctl.step = run && !rst;
    ctl.cfg  = cfgMem[ctxQ];
  end

  assign ctxIdx = ctxQ;
endmodule

// File: rtl/cgra_cell_dp.sv
module cgra_cell_dp
  import cgra_cell_pkg::*;
#(
  parameter int W = DW,
  parameter int NMEM = MEMN
) (
  input  logic         clk,
  input  logic         rst,
  input  ctl_t         ctl,
  input  logic [W-1:0] nIn,
  input  logic [W-1:0] sIn,
  input  logic [W-1:0] eIn,
  input  logic [W-1:0] wIn,
  output logic [W-1:0] result
);
  logic [W-1:0] scratch [NMEM];
  logic [W-1:0] resQ;
  logic [W-1:0] memRd;
  logic [W-1:0] opnd [2];
  src_e         sel  [2];
  logic [W-1:0] aluOut;
  logic [W-1:0] shifted;
  logic [2*W-1:0] prod;

  assign memRd  = scratch[ctl.cfg.memAddr];
  assign sel[0] = ctl.cfg.selA;
  assign sel[1] = ctl.cfg.selB;

  for (genvar g = 0; g < 2; g++) begin : g_opmux
    always_comb begin
      unique case (sel[g])
        SRC_N:     opnd[g] = nIn;
        SRC_S:     opnd[g] = sIn;
        SRC_E:     opnd[g] = eIn;
        SRC_W:     opnd[g] = wIn;
        SRC_MEM:   opnd[g] = memRd;
        SRC_CONST: opnd[g] = ctl.cfg.konst;
        SRC_FB:    opnd[g] = resQ;
        default:   opnd[g] = '0;
      endcase
    end
  end

  assign prod = opnd[0] * opnd[1];

  always_comb begin
    case (ctl.cfg.op)
      OP_ADD:  aluOut = opnd[0] + opnd[1];
      OP_SUB:  aluOut = opnd[0] - opnd[1];
      OP_AND:  aluOut = opnd[0] & opnd[1];
      OP_OR:   aluOut = opnd[0] | opnd[1];
      OP_XOR:  aluOut = opnd[0] ^ opnd[1];
      OP_MUL:  aluOut = prod[W-1:0];
      OP_PASS: aluOut = opnd[0];
      OP_SHL:  aluOut = opnd[0] << opnd[1][SHW-1:0];
      default: aluOut = '0;
    endcase
  end

  assign shifted = aluOut >> ctl.cfg.shamt;

  always_ff @(posedge clk) begin
    if (rst)           resQ <= '0;
    else if (ctl.step) resQ <= shifted;
  end

  always_ff @(posedge clk) begin
    if (ctl.step && ctl.cfg.memWe) scratch[ctl.cfg.memAddr] <= shifted;
  end

  assign result = resQ;
endmodule

// File: rtl/cgra_cell.sv
module cgra_cell
  import cgra_cell_pkg::*;
#(
  parameter int NCTX = CTXN,
  localparam int IW = $clog2(NCTX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            cfgWe,
  input  logic [IW-1:0]   cfgIdx,
  input  logic [CFGW-1:0] cfgWord,
  input  logic [IW-1:0]   lastCtx,
  input  logic [DW-1:0]   nIn,
  input  logic [DW-1:0]   sIn,
  input  logic [DW-1:0]   eIn,
  input  logic [DW-1:0]   wIn,
  output logic [DW-1:0]   result,
  output logic [IW-1:0]   ctxIdx
);
  ctl_t ctl;

  cgra_cell_ctrl #(.NCTX(NCTX)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWord(cfgWord), .lastCtx(lastCtx), .ctl(ctl), .ctxIdx(ctxIdx)
  );

  cgra_cell_dp #(.W(DW), .NMEM(MEMN)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .nIn(nIn), .sIn(sIn), .eIn(eIn),
    .wIn(wIn), .result(result)
  );
endmodule

// File: rtl/cgra_cell_chk.sv
module cgra_cell_chk #(
  parameter int IW = 3,
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [IW-1:0] lastCtx,
  input logic [W-1:0]  result,
  input logic [IW-1:0] ctxIdx
);
  // R1: reset clears state
  p_reset_r1: assert property (@(posedge clk) rst |=> (result == '0 && ctxIdx == '0));
  // R6: halted cell keeps state
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(result) && $stable(ctxIdx)));
  // R9: wrap to zero at or past the last context
  p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (run && ctxIdx >= lastCtx) |=> ctxIdx == '0);
  // R9: plain step below the last context
  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    (run && ctxIdx < lastCtx) |=> ctxIdx == IW'($past(ctxIdx) + IW'(1)));
endmodule

bind cgra_cell cgra_cell_chk #(.IW(IW), .W(cgra_cell_pkg::DW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .lastCtx(lastCtx), .result(result), .ctxIdx(ctxIdx)
);

// File: tb/cgra_cell_bench.sv
module cgra_cell_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        run = 0;
  logic        cfgWe = 0;
  logic [2:0]  cfgIdx = 0;
  logic [34:0] cfgWord = 0;
  logic [2:0]  lastCtx = 0;
  logic [15:0] nIn = 0, sIn = 0, eIn = 0, wIn = 0;
  logic [15:0] result;
  logic [2:0]  ctxIdx;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cgra_cell u_cgra_cell (
    .clk(clk), .rst(rst), .run(run), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWord(cfgWord), .lastCtx(lastCtx), .nIn(nIn), .sIn(sIn), .eIn(eIn),
    .wIn(wIn), .result(result), .ctxIdx(ctxIdx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [34:0] mk(input logic [3:0] op, input logic [2:0] a,
      input logic [2:0] b, input logic [15:0] k, input logic [3:0] sh,
      input logic we, input logic [3:0] ad);
    return {op, a, b, k, sh, we, ad};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic loadCfg(input logic [2:0] idx, input logic [34:0] w);
    @(negedge clk);
    run = 0; cfgWe = 1; cfgIdx = idx; cfgWord = w;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic runCycles(input int n);
    run = 1;
    repeat (n) @(negedge clk);
    run = 0;
  endtask

  task automatic runOne(input logic [34:0] w, input logic [15:0] exp, input string tag);
    loadCfg(0, w);
    lastCtx = 0;
    runCycles(1);
    check(tag, result, exp);
  endtask

  task automatic testReset;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 result after reset", result, 16'h0);
    check("R1 ctx after reset", {13'h0, ctxIdx}, 16'h0);
  endtask

  task automatic testOps;
    nIn = 16'h1234; eIn = 16'h0F0F; sIn = 16'h0002; wIn = 16'h8001;
    runOne(mk(0, 0, 2, 0, 0, 0, 0), 16'h2143, "R4 add");
    runOne(mk(1, 0, 2, 0, 0, 0, 0), 16'h0325, "R4 sub");
    runOne(mk(2, 0, 2, 0, 0, 0, 0), 16'h0204, "R4 and");
    runOne(mk(3, 0, 2, 0, 0, 0, 0), 16'h1F3F, "R4 or");
    runOne(mk(4, 0, 2, 0, 0, 0, 0), 16'h1D3B, "R4 xor");
    runOne(mk(5, 0, 5, 16'h0100, 0, 0, 0), 16'h3400, "R4 mul low half");
    runOne(mk(6, 0, 2, 0, 0, 0, 0), 16'h1234, "R4 pass");
    runOne(mk(7, 0, 5, 16'h0004, 0, 0, 0), 16'h2340, "R4 shl");
    runOne(mk(4'd9, 0, 2, 0, 0, 0, 0), 16'h0000, "R4 unused opcode");
    check("R9 ctx wraps with lastCtx 0", {13'h0, ctxIdx}, 16'h0);
  endtask

  task automatic testSources;
    runOne(mk(1, 3, 1, 0, 0, 0, 0), 16'h7FFF, "R3 west minus south");
    runOne(mk(0, 5, 1, 16'h00AA, 0, 0, 0), 16'h00AC, "R3 const plus south");
    runOne(mk(0, 7, 2, 0, 0, 0, 0), 16'h0F0F, "R3 zero plus east");
    runOne(mk(0, 0, 2, 0, 4'd4, 0, 0), 16'h0214, "R5 shift right 4");
    runOne(mk(6, 5, 7, 16'h8000, 4'd15, 0, 0), 16'h0001, "R5 shift right 15");
  endtask

  task automatic testAccum;
    logic [15:0] base;
    base = result;
    loadCfg(0, mk(0, 6, 5, 16'h0003, 0, 0, 0));
    lastCtx = 0;
    for (int i = 1; i <= 3; i++) begin
      runCycles(1);
      check("R7 accumulate", result, base + 16'(3 * i));
    end
  endtask

  task automatic testScratch;
    loadCfg(0, mk(0, 0, 7, 0, 0, 1, 4'd5));
    loadCfg(1, mk(6, 4, 7, 0, 0, 0, 4'd5));
    lastCtx = 1;
    nIn = 16'h5A5A;
    runCycles(1);
    check("R8 write context result", result, 16'h5A5A);
    check("R9 ctx step to 1", {13'h0, ctxIdx}, 16'h1);
    nIn = 16'h0001;
    runCycles(1);
    check("R8 scratchpad readback", result, 16'h5A5A);
    check("R9 ctx wrap after last", {13'h0, ctxIdx}, 16'h0);
  endtask

  task automatic testSequence;
    loadCfg(0, mk(6, 5, 7, 16'h0010, 0, 0, 0));
    loadCfg(1, mk(6, 5, 7, 16'h0020, 0, 0, 0));
    loadCfg(2, mk(6, 5, 7, 16'h0030, 0, 0, 0));
    lastCtx = 2;
    runCycles(1); check("R9 seq ctx0", result, 16'h0010);
    runCycles(1); check("R9 seq ctx1", result, 16'h0020);
    runCycles(1); check("R9 seq ctx2", result, 16'h0030);
    check("R9 seq wrap index", {13'h0, ctxIdx}, 16'h0);
    runCycles(1); check("R9 seq back to ctx0", result, 16'h0010);
    lastCtx = 0;
    runCycles(1);
    check("R9 ctx above last uses ctx1", result, 16'h0020);
    check("R9 ctx above last wraps", {13'h0, ctxIdx}, 16'h0);
  endtask

  task automatic testHold;
    logic [15:0] r0;
    logic [2:0] c0;
    r0 = result; c0 = ctxIdx;
    nIn = 16'hFFFF; eIn = 16'h1111;
    repeat (3) @(negedge clk);
    check("R6 result held while halted", result, r0);
    check("R6 ctx held while halted", {13'h0, ctxIdx}, {13'h0, c0});
  endtask

  task automatic testLoadIgnored;
    lastCtx = 0;
    @(negedge clk);
    run = 1; cfgWe = 1; cfgIdx = 0; cfgWord = mk(6, 5, 7, 16'h0099, 0, 0, 0);
    @(negedge clk);
    run = 0; cfgWe = 0;
    check("R2 running cycle uses old word", result, 16'h0010);
    runCycles(1);
    check("R2 load during run ignored", result, 16'h0010);
    loadCfg(0, mk(6, 5, 7, 16'h0077, 0, 0, 0));
    runCycles(1);
    check("R2 halted load takes effect", result, 16'h0077);
  endtask

  task automatic testMidReset;
    loadCfg(0, mk(6, 5, 7, 16'h0042, 0, 0, 0));
    loadCfg(1, mk(6, 5, 7, 16'h0043, 0, 0, 0));
    lastCtx = 1;
    runCycles(1);
    @(negedge clk);
    run = 1; rst = 1;
    @(negedge clk);
    run = 0; rst = 0;
    check("R1 reset while running clears result", result, 16'h0);
    check("R1 reset while running clears ctx", {13'h0, ctxIdx}, 16'h0);
  endtask

  initial begin
    testReset();
    testOps();
    testSources();
    testAccum();
    testScratch();
    testSequence();
    testHold();
    testLoadIgnored();
    testMidReset();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule